// File: doc/BRIEF.md
# Link Retransmission Sender with Replay Buffer

This block is the transmitting end of one switch-to-switch link that recovers from bit errors by itself. It takes flits from an upstream valid/ready source and stores each in a circular replay buffer. It puts each flit on the link together with a sequence tag and a CRC-8 check byte. The stored copy is kept until the far end confirms it.

The receiver checks the CRC of every flit as it arrives. It answers on a return channel: a positive response carries the tag of the newest flit it accepted, and a negative response carries the tag of a flit that failed the check. A positive response is cumulative. It releases every held copy up to and including the quoted tag. A negative response makes the sender go back to the rejected flit and replay everything from that flit onward, in the original order. The receiver drops all flits that follow a bad one until the replayed copy arrives, so delivery stays in order.

The buffer is tracked by three pointers: oldest unconfirmed, next to transmit, and write. Its depth has to cover the round trip of the link, which is about twice the number of pipeline stages on the link plus the logic latency at both ends. When it is full, upstream is held off.

Top module: `link_replay_tx`

## Requirements
- R1: After reset the block accepts input (`in_ready` = 1) and drives no flit (`out_valid` = 0).
- R2: A flit accepted at a clock edge is driven on the link after the following edge, unless earlier flits are still waiting to go out. Flits leave in acceptance order. The tag `out_seq` counts accepted flits modulo 2^SEQ_W, where SEQ_W = log2(DEPTH)+1, so two consecutive link flits always carry tags that differ by one.
- R3: `out_crc` is the CRC-8 of `out_data` with generator x^8+x^2+x+1 (0x07), initial value 0, data fed most significant bit first, with no final inversion.
- R4: When DEPTH flits are held unconfirmed, `in_ready` is 0 and no flit is taken. No accepted flit is ever lost or overwritten.
- R5: A positive response (`rsp_valid`=1, `rsp_nack`=0) with tag t releases every held flit up to and including t. The freed slots show up as `in_ready` = 1 after that edge.
- R6: A negative response (`rsp_valid`=1, `rsp_nack`=1) with tag t releases the flits before t. The next link cycle is empty, and the cycle after that carries flit t again. The flits after t follow in order.
- R7: A response whose tag does not lie between the oldest unconfirmed flit (inclusive) and the next flit to send (exclusive) has no effect.
- R8: The link carries no flit (`out_valid` = 0) when every accepted flit has already been sent.
- R9: With a receiver that checks the CRC and drops flits after an error, the delivered stream equals the accepted stream exactly, even when errors are injected, including errors on a replayed flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream flit present |
| in_data | input | DATA_W | Upstream flit payload |
| in_ready | output | 1 | Replay buffer has a free slot |
| out_valid | output | 1 | Link flit present this cycle |
| out_data | output | DATA_W | Link flit payload |
| out_crc | output | 8 | CRC-8 of the link payload |
| out_seq | output | SEQ_W | Sequence tag of the link flit |
| rsp_valid | input | 1 | Return-channel response present |
| rsp_nack | input | 1 | 1 = negative response, 0 = positive |
| rsp_seq | input | SEQ_W | Tag quoted by the response |

## Verification
Each result has a fixed due cycle:
- An accepted flit can appear on the link one cycle after the edge that takes it.
- A positive response frees slots in the same edge that samples it, so `in_ready` changes after that edge.
- A negative response gives one empty link cycle and then the replayed flit.

The bench drives inputs and reads outputs on the falling edge. At each falling edge it compares all outputs with a behavioural model that it steps once per rising edge, so each expectation is checked in exactly the cycle it falls due. A separate check follows every negative response through its empty cycle and the replay that comes after it.

// File: rtl/link_replay_tx.sv
module link_replay_tx #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SEQ_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [7:0]        out_crc,
  output logic [SEQ_W-1:0]  out_seq,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [SEQ_W-1:0]  rsp_seq
);

  function automatic logic [7:0] crc8(input logic [DATA_W-1:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [SEQ_W-1:0]  old_q, snd_q, wr_q;
  logic [SEQ_W-1:0]  used, inflight, rdiff;
  logic              rsp_hit, push, send_go;
  logic [DATA_W-1:0] rd_data;

  assign used     = wr_q - old_q;
  assign inflight = snd_q - old_q;
  assign rdiff    = rsp_seq - old_q;
  assign rsp_hit  = rsp_valid && (rdiff < inflight);
  assign in_ready = (used != SEQ_W'(DEPTH));
  assign push     = in_valid && in_ready;
  assign send_go  = (snd_q != wr_q);
  assign rd_data  = mem[snd_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[IDX_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      snd_q <= '0;
      wr_q  <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (rsp_hit && rsp_nack) begin
        old_q <= rsp_seq;
        snd_q <= rsp_seq;
      end else begin
        if (rsp_hit) old_q <= rsp_seq + 1'b1;
        if (send_go) snd_q <= snd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_crc   <= '0;
      out_seq   <= '0;
    end else if (rsp_hit && rsp_nack) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= send_go;
      if (send_go) begin
        out_data <= rd_data;
        out_crc  <= crc8(rd_data);
        out_seq  <= snd_q;
      end
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> wr_q == $past(wr_q));

  p_fill_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    used <= SEQ_W'(DEPTH));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_seq == SEQ_W'($past(out_seq) + 1'b1));

  p_nack_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && rsp_nack |=> !out_valid);

  p_nack_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && rsp_nack |=> ##1 (out_valid && out_seq == $past(rsp_seq, 2)));

  p_window_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= used);

  p_crc_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_crc == crc8(out_data));

endmodule

// File: tb/link_replay_tx_tb.sv
module link_replay_tx_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int SEQ_W  = $clog2(DEPTH) + 1;
  localparam int M      = 1 << SEQ_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic [DATA_W-1:0] out_data;
  logic [7:0] out_crc;
  logic [SEQ_W-1:0] out_seq;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [SEQ_W-1:0] rsp_seq = '0;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_replay_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_crc(out_crc), .out_seq(out_seq), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_seq(rsp_seq));

  function automatic logic [7:0] crc_ref(input logic [DATA_W-1:0] d);
    logic [DATA_W+7:0] r;
    r = {d, 8'h00};
    for (int i = DATA_W + 7; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int m_old = 0, m_nxt = 0, m_wr = 0;
  logic [DATA_W-1:0] store [int];
  logic mo_v = 0;
  logic [DATA_W-1:0] mo_d = '0;
  int mo_seq = 0;
  logic [DATA_W-1:0] sent_q [$];
  logic [DATA_W-1:0] got_q [$];

  // receiver model state
  int exp_n = 0, tx_n = 0;
  bit disc = 0, owed = 0;

  function automatic bit corrupt(input int n);
    return n == 5 || n == 20 || n == 21 || n == 70 || n == 71 || n == 72;
  endfunction

  initial begin
    int r6_st = 0, r6_tag = 0;
    logic [DATA_W-1:0] next_val = 16'h1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
    for (int cyc = 0; cyc < 400; cyc++) begin
      bit ack_en, every, bogus, rv, rn, acc, hit;
      int rt, diff, absn;
      logic [DATA_W-1:0] d;
      ack_en = !(cyc >= 80 && cyc < 160);
      every  = (cyc < 80);
      bogus  = (cyc == 150);
      // compare outputs against model
      check("R4 in_ready", in_ready, (m_wr - m_old) != DEPTH);
      check("R8 out_valid", out_valid, mo_v);
      if (mo_v) begin
        check("R2 out_data", out_data, mo_d);
        check("R2 out_seq", out_seq, mo_seq % M);
        check("R3 out_crc", out_crc, crc_ref(out_data));
      end
      if (cyc == 152) check("R7 full after stray response", in_ready, 0);
      if (r6_st == 1) begin
        check("R6 empty cycle", out_valid, 0);
        r6_st = 2;
      end else if (r6_st == 2) begin
        check("R6 replay valid", out_valid, 1);
        check("R6 replay tag", out_seq, r6_tag);
        r6_st = 0;
      end
      // receiver model
      rv = 0; rn = 0; rt = 0;
      if (out_valid) begin
        tx_n++;
        d = out_data;
        if (corrupt(tx_n)) d = d ^ 16'h0100;
        if (crc_ref(d) != out_crc) begin
          if (!disc || out_seq == exp_n % M) begin
            rv = 1; rn = 1; rt = out_seq; disc = 1;
          end
        end else if (out_seq == exp_n % M) begin
          got_q.push_back(d);
          exp_n++;
          disc = 0;
          if (ack_en && (every || exp_n % 3 == 0)) begin
            rv = 1; rt = (exp_n - 1) % M; owed = 0;
          end else owed = 1;
        end else if (!disc) begin
          check("R9 in-order tag", out_seq, exp_n % M);
        end
      end else if (ack_en && owed) begin
        rv = 1; rt = (exp_n - 1) % M; owed = 0;
      end
      if (bogus) begin
        rv = 1; rn = 0; rt = m_wr % M;
      end
      rsp_valid = rv; rsp_nack = rn; rsp_seq = SEQ_W'(rt);
      // upstream
      in_valid = (cyc < 330) && ((cyc >= 80) || (cyc % 3 != 0));
      in_data  = next_val;
      // model step
      acc = in_valid && ((m_wr - m_old) != DEPTH);
      hit = 0; absn = 0;
      if (rv) begin
        diff = ((rt - (m_old % M)) + M) % M;
        if (diff < m_nxt - m_old) begin hit = 1; absn = m_old + diff; end
      end
      if (hit && rn) begin
        m_old = absn; m_nxt = absn; mo_v = 0;
        r6_st = 1; r6_tag = rt;
      end else begin
        if (hit) m_old = absn + 1;
        if (m_nxt != m_wr) begin
          mo_v = 1; mo_d = store[m_nxt]; mo_seq = m_nxt; m_nxt++;
        end else mo_v = 0;
      end
      if (acc) begin
        store[m_wr] = in_data; m_wr++;
        sent_q.push_back(in_data);
        next_val = next_val + 16'h0013;
      end
      @(negedge clk);
    end
    rsp_valid = 0;
    in_valid = 0;
    check("R5 all released", in_ready, 1);
    check("R5 model drained", m_wr - m_old, 0);
    check("R9 delivered count", got_q.size(), sent_q.size());
    for (int i = 0; i < sent_q.size() && i < got_q.size(); i++)
      check("R9 delivered data", got_q[i], sent_q[i]);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule